// File: doc/BRIEF.md
# Microprogram Sequencer Next-Address Logic

This block decides which microaddress a microcoded control unit fetches next. Every clock it updates a microprogram counter, whose value addresses the control store. The inputs are the sequencing fields of the current microinstruction: a source select, a condition select, a stack operation and a branch address. It also receives a start address from the opcode lookup table, an external address used for reset and exceptions, two case bits and the datapath status flags N and Z.

When the selected condition holds, the counter loads the chosen source. The source can be the opcode start address, the external address, the branch address, or the branch address with the case bits OR-merged in, which gives a four-way branch in a single clock. When the condition fails, the counter simply increments. A four-entry return stack lets the microcode call shared sequences as subroutines and return from them. Stack overflow and underflow set a sticky error flag.

The control store and the datapath sit outside the block. Reset and exception are assumed to be synchronous to the clock already.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst_n` is low, every clock edge loads `upc` with `ext_addr`, empties the return stack and clears `stk_err`. Reset takes priority over `exc`.
- R2: With `rst_n` high and `exc` high, the next `upc` is `ext_addr` whatever the branch fields say, and the return stack is neither pushed nor popped.
- R3: `br_cond` selects the test: 000 never, 001 always, 010 N clear, 011 N set, 100 Z clear, 101 Z set, and 110 or 111 never. When the test fails, the next `upc` is `upc`+1.
- R4: When the test passes and `br_stk` is not a return, `br_src` picks the next `upc`: 00 `opc_addr`, 01 `ext_addr`, 10 `br_addr`, 11 the multiway target.
- R5: The multiway target is `br_addr` with `case_bits[1:0]` ORed into bits 3:2 (bit 0 is the LSB), and it is reached in one clock.
- R6: The increment wraps modulo 256, so from 0xFF the counter goes to 0x00.
- R7: `br_stk` encodes 00 none, 01 call, 10 return, 11 none. A call whose test passes pushes `upc`+1 and jumps to the selected target.
- R8: A return whose test passes loads `upc` with the most recently pushed address and pops it. The stack is last-in first-out and 4 entries deep.
- R9: A call on a full stack still jumps but drops the push. A return on an empty stack moves to `upc`+1. Both cases set `stk_err`, which stays set until reset.
- R10: A call or return whose test fails leaves the stack unchanged and moves to `upc`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc | input | 1 | Exception request, synchronous |
| ext_addr | input | 8 | External address for reset and exception |
| opc_addr | input | 8 | Start address from the opcode lookup table |
| br_src | input | 2 | Source select of the current microinstruction |
| br_cond | input | 3 | Condition select of the current microinstruction |
| br_stk | input | 2 | Stack operation of the current microinstruction |
| br_addr | input | 8 | Branch-address field of the current microinstruction |
| case_bits | input | 2 | Case bits for the multiway branch |
| flag_n | input | 1 | Negative status flag |
| flag_z | input | 1 | Zero status flag |
| upc | output | 8 | Microprogram counter, the control-store address |
| stk_err | output | 1 | Sticky return-stack overflow or underflow flag |

## Verification
The hardest state to reach is a full return stack followed by a fifth call. After that call the bench must show that the jump happened, that the push was dropped and that the error flag became set. The stimulus runs four nested calls, each to a fresh target, so that every pushed return address is distinct. It then makes one more call and unwinds with returns. The order in which the returns come back shows that no entry was overwritten. A final return on the empty stack, and an exception raised in the same cycle as a call, check that neither case disturbs the stack.

// File: rtl/useq_pkg.sv
// Package: encodings of the sequencing fields shared by the sequencer and its checker.
// Assumes the field widths given here match the microinstruction format.
package useq_pkg;
    localparam int SRC_W  = 2;
    localparam int COND_W = 3;
    localparam int STK_W  = 2;

    localparam logic [SRC_W-1:0] SRC_OPC  = 2'b00;
    localparam logic [SRC_W-1:0] SRC_EXT  = 2'b01;
    localparam logic [SRC_W-1:0] SRC_BRA  = 2'b10;
    localparam logic [SRC_W-1:0] SRC_MWAY = 2'b11;

    localparam logic [COND_W-1:0] CND_NEVER  = 3'b000;
    localparam logic [COND_W-1:0] CND_ALWAYS = 3'b001;
    localparam logic [COND_W-1:0] CND_NCLR   = 3'b010;
    localparam logic [COND_W-1:0] CND_NSET   = 3'b011;
    localparam logic [COND_W-1:0] CND_ZCLR   = 3'b100;
    localparam logic [COND_W-1:0] CND_ZSET   = 3'b101;

    localparam logic [STK_W-1:0] STK_NONE = 2'b00;
    localparam logic [STK_W-1:0] STK_CALL = 2'b01;
    localparam logic [STK_W-1:0] STK_RET  = 2'b10;
endpackage

// File: rtl/useq_cond_eval.sv
// Condition evaluator: decides whether this microinstruction's branch is taken.
// Assumes the flags are stable within the cycle. Codes not listed mean "never".
module useq_cond_eval
    import useq_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic              flag_n,
    input  logic              flag_z,
    output logic              taken
);
    // Decode the condition select against the status flags.
    always_comb begin
        case (cond)
            CND_ALWAYS: taken = 1'b1;
            CND_NCLR:   taken = ~flag_n;
            CND_NSET:   taken = flag_n;
            CND_ZCLR:   taken = ~flag_z;
            CND_ZSET:   taken = flag_z;
            default:    taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/useq_target_mux.sv
// Target selector: picks the non-incremented next address, including the
// multiway target formed by ORing case bits into the branch address.
// Assumes MW_LSB + CASE_W <= AW.
module useq_target_mux
    import useq_pkg::*;
#(
    parameter int AW     = 8,
    parameter int CASE_W = 2,
    parameter int MW_LSB = 2
) (
    input  logic [SRC_W-1:0]  src,
    input  logic [AW-1:0]     opc_addr,
    input  logic [AW-1:0]     ext_addr,
    input  logic [AW-1:0]     br_addr,
    input  logic [CASE_W-1:0] case_bits,
    output logic [AW-1:0]     target
);
    logic [AW-1:0] case_shifted;

    // Place the case bits at their field position inside the address.
    always_comb case_shifted = AW'(case_bits) << MW_LSB;

    // Select the source named by the microinstruction.
    always_comb begin
        case (src)
            SRC_OPC:  target = opc_addr;
            SRC_EXT:  target = ext_addr;
            SRC_BRA:  target = br_addr;
            default:  target = br_addr | case_shifted;
        endcase
    end
endmodule

// File: rtl/useq_ret_stack.sv
// Return stack: a LIFO of saved microaddresses for micro-subroutines.
// Assumes push and pop are never requested together. A push on a full stack or a
// pop on an empty stack is dropped and sets a sticky error that only reset clears.
module useq_ret_stack #(
    parameter int AW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] top_data,
    output logic          empty,
    output logic          err
);
    localparam int SPW = $clog2(DEPTH + 1);
    localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0]  mem [DEPTH];
    logic [SPW-1:0] sp;
    logic           full;
    logic [IW-1:0]  wr_idx;
    logic [IW-1:0]  rd_idx;

    // Derive the occupancy flags and the slot indices.
    always_comb begin
        full   = (sp == SPW'(DEPTH));
        empty  = (sp == '0);
        wr_idx = sp[IW-1:0];
        rd_idx = wr_idx - IW'(1);
    end

    // Present the most recent entry.
    always_comb top_data = mem[rd_idx];

    // Write a pushed address into the next free slot.
    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_idx] <= push_data;
    end

    // Track the stack pointer and the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp  <= '0;
            err <= 1'b0;
        end else begin
            if (push && !full)      sp <= sp + SPW'(1);
            else if (pop && !empty) sp <= sp - SPW'(1);
            if ((push && full) || (pop && empty)) err <= 1'b1;
        end
    end
endmodule

// File: rtl/useq_next_addr.sv
// Next-address logic of a microprogram sequencer. Each cycle it chooses among
// the increment, the opcode start, the external address and the branch target
// (plain or multiway), and it performs micro-subroutine calls and returns.
// Priority: reset, then exception, then the microinstruction's own branch.
// Assumes rst_n and exc are already synchronous to clk.
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int AW        = 8,
    parameter int STK_DEPTH = 4,
    parameter int CASE_W    = 2,
    parameter int MW_LSB    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc,
    input  logic [AW-1:0]     ext_addr,
    input  logic [AW-1:0]     opc_addr,
    input  logic [SRC_W-1:0]  br_src,
    input  logic [COND_W-1:0] br_cond,
    input  logic [STK_W-1:0]  br_stk,
    input  logic [AW-1:0]     br_addr,
    input  logic [CASE_W-1:0] case_bits,
    input  logic              flag_n,
    input  logic              flag_z,
    output logic [AW-1:0]     upc,
    output logic              stk_err
);
    logic          taken;
    logic [AW-1:0] target;
    logic [AW-1:0] upc_inc;
    logic [AW-1:0] stk_top;
    logic          stk_empty;
    logic          do_call;
    logic          do_ret;
    logic [AW-1:0] nxt_addr;

    useq_cond_eval u_cond (
        .cond   (br_cond),
        .flag_n (flag_n),
        .flag_z (flag_z),
        .taken  (taken)
    );

    useq_target_mux #(.AW(AW), .CASE_W(CASE_W), .MW_LSB(MW_LSB)) u_tgt (
        .src       (br_src),
        .opc_addr  (opc_addr),
        .ext_addr  (ext_addr),
        .br_addr   (br_addr),
        .case_bits (case_bits),
        .target    (target)
    );

    useq_ret_stack #(.AW(AW), .DEPTH(STK_DEPTH)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_call),
        .pop       (do_ret),
        .push_data (upc_inc),
        .top_data  (stk_top),
        .empty     (stk_empty),
        .err       (stk_err)
    );

    // Qualify the stack operations; an exception suppresses them.
    always_comb begin
        upc_inc = upc + AW'(1);
        do_call = !exc && taken && (br_stk == STK_CALL);
        do_ret  = !exc && taken && (br_stk == STK_RET);
    end

    // Choose the next microaddress in priority order.
    always_comb begin
        if (exc)                     nxt_addr = ext_addr;
        else if (do_ret)             nxt_addr = stk_empty ? upc_inc : stk_top;
        else if (taken)              nxt_addr = target;
        else                         nxt_addr = upc_inc;
    end

    // Update the microprogram counter; reset loads the external address.
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= ext_addr;
        else        upc <= nxt_addr;
    end
endmodule

// File: rtl/useq_checks.sv
// Checker for the sequencer: temporal properties over its ports, attached by bind.
// Assumes the default field encodings from useq_pkg.
module useq_checks
    import useq_pkg::*;
#(
    parameter int AW     = 8,
    parameter int CASE_W = 2,
    parameter int MW_LSB = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc,
    input logic [AW-1:0]     ext_addr,
    input logic [SRC_W-1:0]  br_src,
    input logic [COND_W-1:0] br_cond,
    input logic [STK_W-1:0]  br_stk,
    input logic [AW-1:0]     br_addr,
    input logic [CASE_W-1:0] case_bits,
    input logic [AW-1:0]     upc,
    input logic              stk_err
);
    logic          past_valid = 1'b0;
    logic          past_rst   = 1'b0;
    logic [AW-1:0] past_ext   = '0;

    // Remember the reset and external address from the previous edge.
    always_ff @(posedge clk) begin
        past_valid <= 1'b1;
        past_rst   <= !rst_n;
        past_ext   <= ext_addr;
    end

    // A reset cycle loads the external address (R1).
    always @(posedge clk) begin
        if (past_valid && past_rst)
            p_reset_load_r1: assert (upc == past_ext)
                else $error("reset did not load the external address");
        if (past_valid && past_rst)
            p_reset_clear_r1: assert (!stk_err)
                else $error("reset did not clear the stack error");
    end

    p_exc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exc |=> (upc == $past(ext_addr)));

    p_never_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc && br_cond == CND_NEVER) |=> (upc == $past(upc) + AW'(1)));

    p_mway_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc && br_cond == CND_ALWAYS && br_src == SRC_MWAY && br_stk == STK_NONE)
        |=> ((upc & ~(AW'({CASE_W{1'b1}}) << MW_LSB)) ==
             ($past(br_addr) & ~(AW'({CASE_W{1'b1}}) << MW_LSB))) &&
            (upc[MW_LSB +: CASE_W] == ($past(br_addr[MW_LSB +: CASE_W]) | $past(case_bits))));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err);
endmodule

bind useq_next_addr useq_checks #(.AW(AW), .CASE_W(CASE_W), .MW_LSB(MW_LSB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc       (exc),
    .ext_addr  (ext_addr),
    .br_src    (br_src),
    .br_cond   (br_cond),
    .br_stk    (br_stk),
    .br_addr   (br_addr),
    .case_bits (case_bits),
    .upc       (upc),
    .stk_err   (stk_err)
);

// File: tb/tb_useq_next_addr.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected counter and error values, and a
// monitor compares them just after the clock edge that produces them.
module tb_useq_next_addr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exc = 1'b0;
    logic [7:0] ext_addr = 8'h10;
    logic [7:0] opc_addr = 8'h00;
    logic [1:0] br_src = 2'b00;
    logic [2:0] br_cond = 3'b000;
    logic [1:0] br_stk = 2'b00;
    logic [7:0] br_addr = 8'h00;
    logic [1:0] case_bits = 2'b00;
    logic       flag_n = 1'b0;
    logic       flag_z = 1'b0;
    logic [7:0] upc;
    logic       stk_err;

    localparam logic [2:0] NEV = 3'd0, ALW = 3'd1, NCL = 3'd2, NST = 3'd3, ZCL = 3'd4, ZST = 3'd5;
    localparam logic [1:0] SOPC = 2'd0, SEXT = 2'd1, SBRA = 2'd2, SMW = 2'd3;
    localparam logic [1:0] SNO = 2'd0, SCALL = 2'd1, SRET = 2'd2;

    typedef struct {
        logic [7:0] upc;
        logic       err;
        int         req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #4 clk = ~clk;

    useq_next_addr dut (
        .clk(clk), .rst_n(rst_n), .exc(exc), .ext_addr(ext_addr), .opc_addr(opc_addr),
        .br_src(br_src), .br_cond(br_cond), .br_stk(br_stk), .br_addr(br_addr),
        .case_bits(case_bits), .flag_n(flag_n), .flag_z(flag_z),
        .upc(upc), .stk_err(stk_err)
    );

    // Monitor: compare each expected item one step after the producing edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (upc !== e.upc || stk_err !== e.err) begin
                n_fail++;
                $display("FAIL R%0d: upc=%h err=%b expected upc=%h err=%b",
                         e.req, upc, stk_err, e.upc, e.err);
            end
        end
    end

    // Driver for one reset cycle.
    task automatic do_reset(input logic [7:0] ext, input logic ex, input int req);
        @(negedge clk);
        rst_n = 1'b0; exc = ex; ext_addr = ext;
        br_cond = NEV; br_stk = SNO;
        exp_q.push_back('{upc: ext, err: 1'b0, req: req});
    endtask

    // Driver for one microinstruction.
    task automatic step(input logic [2:0] cond, input logic [1:0] src, input logic [1:0] stk,
                        input logic [7:0] addr, input logic [1:0] cs, input logic n,
                        input logic z, input logic ex, input logic [7:0] ext,
                        input logic [7:0] opc, input logic [7:0] e_upc,
                        input logic e_err, input int req);
        @(negedge clk);
        rst_n = 1'b1; br_cond = cond; br_src = src; br_stk = stk; br_addr = addr;
        case_bits = cs; flag_n = n; flag_z = z; exc = ex; ext_addr = ext; opc_addr = opc;
        exp_q.push_back('{upc: e_upc, err: e_err, req: req});
    endtask

    initial begin
        do_reset(8'h10, 1'b0, 1);   // R1 reset loads external address
        do_reset(8'h10, 1'b0, 1);   // R1
        step(NEV, SBRA, SNO, 8'h77, 0, 0, 0, 0, 8'h10, 8'h00, 8'h11, 0, 3);  // R3 never
        step(3'd6, SBRA, SNO, 8'h77, 0, 1, 1, 0, 8'h10, 8'h00, 8'h12, 0, 3); // R3 spare code
        step(ALW, SBRA, SNO, 8'h40, 0, 0, 0, 0, 8'h10, 8'h00, 8'h40, 0, 4);  // R4 branch addr
        step(NST, SBRA, SNO, 8'h20, 0, 0, 0, 0, 8'h10, 8'h00, 8'h41, 0, 3);  // R3 N set fails
        step(NST, SBRA, SNO, 8'h20, 0, 1, 0, 0, 8'h10, 8'h00, 8'h20, 0, 3);  // R3 N set passes
        step(NCL, SBRA, SNO, 8'h30, 0, 1, 0, 0, 8'h10, 8'h00, 8'h21, 0, 3);  // R3 N clear fails
        step(NCL, SBRA, SNO, 8'h30, 0, 0, 0, 0, 8'h10, 8'h00, 8'h30, 0, 3);  // R3 N clear passes
        step(ZST, SBRA, SNO, 8'h50, 0, 0, 1, 0, 8'h10, 8'h00, 8'h50, 0, 3);  // R3 Z set passes
        step(ZCL, SBRA, SNO, 8'h60, 0, 0, 1, 0, 8'h10, 8'h00, 8'h51, 0, 3);  // R3 Z clear fails
        step(ZCL, SBRA, SNO, 8'h60, 0, 0, 0, 0, 8'h10, 8'h00, 8'h60, 0, 3);  // R3 Z clear passes
        step(ALW, SOPC, SNO, 8'h07, 0, 0, 0, 0, 8'h10, 8'h80, 8'h80, 0, 4);  // R4 opcode start
        step(ALW, SEXT, SNO, 8'h07, 0, 0, 0, 0, 8'h90, 8'h80, 8'h90, 0, 4);  // R4 external
        step(ALW, SMW, SNO, 8'hA0, 2, 0, 0, 0, 8'h10, 8'h00, 8'hA8, 0, 5);   // R5 case 2
        step(ALW, SMW, SNO, 8'hB0, 3, 0, 0, 0, 8'h10, 8'h00, 8'hBC, 0, 5);   // R5 case 3
        step(ALW, SMW, SNO, 8'hC3, 1, 0, 0, 0, 8'h10, 8'h00, 8'hC7, 0, 5);   // R5 OR keeps low bits
        step(ALW, SBRA, SNO, 8'hFF, 0, 0, 0, 0, 8'h10, 8'h00, 8'hFF, 0, 4);  // R4
        step(NEV, SBRA, SNO, 8'h00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h00, 0, 6);  // R6 wrap
        step(ALW, SBRA, SCALL, 8'h70, 0, 0, 0, 0, 8'h10, 8'h00, 8'h70, 0, 7); // R7 push 01
        step(ALW, SBRA, SCALL, 8'h78, 0, 0, 0, 0, 8'h10, 8'h00, 8'h78, 0, 7); // R7 push 71
        step(NEV, SBRA, SRET, 8'h00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h79, 0, 10); // R10 no pop
        step(ZST, SBRA, SCALL, 8'h05, 0, 0, 0, 0, 8'h10, 8'h00, 8'h7A, 0, 10);// R10 no push
        step(ALW, SBRA, SRET, 8'h00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h71, 0, 8);  // R8 LIFO
        step(ALW, SBRA, SRET, 8'h00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h01, 0, 8);  // R8
        step(ALW, SBRA, SRET, 8'h00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h02, 1, 9);  // R9 underflow
        step(NEV, SBRA, SNO, 8'h00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h03, 1, 9);   // R9 sticky
        step(ALW, SBRA, SCALL, 8'h33, 0, 0, 0, 1, 8'h05, 8'h00, 8'h05, 1, 2); // R2 exception wins
        step(ALW, SBRA, SRET, 8'h00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h06, 1, 2);  // R2 nothing pushed
        do_reset(8'h12, 1'b1, 1);   // R1 reset over exception, clears error
        step(ALW, SBRA, SCALL, 8'h20, 0, 0, 0, 0, 8'h10, 8'h00, 8'h20, 0, 7); // R7 push 13
        step(ALW, SBRA, SCALL, 8'h30, 0, 0, 0, 0, 8'h10, 8'h00, 8'h30, 0, 7); // push 21
        step(ALW, SBRA, SCALL, 8'h40, 0, 0, 0, 0, 8'h10, 8'h00, 8'h40, 0, 7); // push 31
        step(ALW, SBRA, SCALL, 8'h50, 0, 0, 0, 0, 8'h10, 8'h00, 8'h50, 0, 7); // push 41, full
        step(ALW, SBRA, SCALL, 8'h60, 0, 0, 0, 0, 8'h10, 8'h00, 8'h60, 1, 9); // R9 overflow
        step(ALW, SBRA, SRET, 8'h00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h41, 1, 8);  // R8
        step(ALW, SBRA, SRET, 8'h00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h31, 1, 8);  // R8
        step(ALW, SBRA, SRET, 8'h00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h21, 1, 8);  // R8
        step(ALW, SBRA, SRET, 8'h00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h13, 1, 8);  // R8 oldest intact
        step(ALW, SBRA, SRET, 8'h00, 0, 0, 0, 0, 8'h10, 8'h00, 8'h14, 1, 9);  // R9 empty again
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule